// File: doc/BRIEF.md
# Direct-Mapped Read Cache with Victim Buffer

This block is a read-only first-level cache. The main array is direct mapped, one data word per line. A small fully associative victim buffer sits beside it and catches lines that refills push out of the main array. When a later request misses the main array but finds its line in the buffer, the two lines trade places: the buffered line returns to the main array, and the line it displaces takes the vacated buffer slot. This recovers lines lost to index conflicts without a trip to the next memory level.

Addresses are line addresses. The processor side presents a request with a valid/ready handshake and gets back a one-cycle response with the data and a hit flag. When a request misses in both structures, the block sends a single-cycle refill request to memory and waits for the matching data. Three saturating counters report main-array hits, victim-buffer hits and full misses.

Top module: `dmvc_cache`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid and mem_req_valid are 0, all three counters are 0, and every line is invalid, so the first access to any address is a full miss.
- R2: A line address maps to main-array index `addr mod SETS`, which is the low log2(SETS) bits. The remaining upper bits are the tag. Lines with different indices can be present at the same time.
- R3: A request that misses in both structures drops req_ready and pulses mem_req_valid for exactly one cycle, one cycle after acceptance, carrying the requested line address. One cycle after mem_rsp_valid, rsp_valid rises with rsp_hit=0 and rsp_data equal to the returned word, and req_ready returns to 1.
- R4: A main-array hit gives rsp_valid=1, rsp_hit=1 and the stored word one cycle after acceptance. It issues no memory request.
- R5: When a refill replaces a valid main-array line, that line is placed in the victim buffer, so the next request for it is a victim hit with no memory request.
- R6: A victim hit responds two cycles after acceptance, with rsp_hit=1 and the buffered word, and issues no memory request. After the response, the requested line hits in the main array, and the line it displaced is held in the victim buffer.
- R7: A line address is never present in both the main array and the victim buffer. A line that was swapped back is served as a main-array hit.
- R8: Replacing an invalid main-array line inserts nothing into the victim buffer and uses no victim slot.
- R9: Victim slots are filled in round-robin order. When the buffer is full, the next eviction overwrites the slot filled longest ago, and that line then becomes a full miss.
- R10: Each counter saturates at 2^CNT_W-1 and never decreases except at reset.
- R11: The main-hit, victim-hit and miss counters each increase by one for every response of their class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor request valid |
| req_addr | input | ADDR_W | Requested line address |
| req_ready | output | 1 | Block can accept a request |
| rsp_valid | output | 1 | Response valid, one cycle |
| rsp_hit | output | 1 | 1 when served from the main array or the victim buffer |
| rsp_data | output | DATA_W | Response data word |
| mem_req_valid | output | 1 | Refill request pulse |
| mem_req_addr | output | ADDR_W | Refill line address |
| mem_rsp_valid | input | 1 | Refill data valid |
| mem_rsp_data | input | DATA_W | Refill data word |
| main_hit_cnt | output | CNT_W | Saturating main-array hit count |
| victim_hit_cnt | output | CNT_W | Saturating victim-buffer hit count |
| miss_cnt | output | CNT_W | Saturating full-miss count |

## Verification
The bench builds the block with SETS=4, VB_DEPTH=4 and CNT_W=4, and keeps 16-bit addresses and 32-bit data. With only four sets, a handful of addresses on one index produce a chain of conflict evictions. A four-entry buffer fills and then wraps after five victims, which exposes both FIFO discard and the slot that an invalid replacement must not consume. Four-bit counters reach saturation after fifteen hits, so twenty repeated hits check the ceiling.

// File: rtl/dmvc_pkg.sv
`timescale 1ns/1ps
package dmvc_pkg;

  // Controller phases.
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,   // accepting requests, main lookup on req_addr
    ST_SWAP = 2'd1,   // exchanging a victim-buffer line with the main line
    ST_WAIT = 2'd2    // refill outstanding at the next level
  } ctl_state_e;

  // Counter slots in the counter bank.
  localparam int CNT_MAIN   = 0;
  localparam int CNT_VICTIM = 1;
  localparam int CNT_MISS   = 2;
  localparam int CNT_NUM    = 3;

endpackage

// File: rtl/dmvc_main_array.sv
`timescale 1ns/1ps
module dmvc_main_array #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int SETS   = 16,
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data
);

  logic [SETS-1:0]             valid_q;
  logic [SETS-1:0]             valid_d;
  logic [SETS-1:0][TAG_W-1:0]  tag_q;
  logic [SETS-1:0][DATA_W-1:0] data_q;

  // Read port: the single line selected by the index.
  assign rd_valid = valid_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_data  = data_q[rd_idx];

  // A line becomes valid once written. Lines are never invalidated outside reset.
  always_comb begin
    valid_d = valid_q;
    if (wr_en) begin
      valid_d[wr_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else begin
      valid_q <= valid_d;
    end
  end

  // Tag and data storage carries no reset. The valid bits guard it.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      data_q[wr_idx] <= wr_data;
    end
  end

endmodule

// File: rtl/dmvc_victim_buf.sv
`timescale 1ns/1ps
module dmvc_victim_buf #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  localparam int SLOT_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  // parallel search
  input  logic [ADDR_W-1:0] lk_key,
  output logic              lk_hit,
  output logic [SLOT_W-1:0] lk_slot,
  output logic [DATA_W-1:0] lk_data,
  // FIFO insertion of an evicted line
  input  logic              ins_en,
  input  logic [ADDR_W-1:0] ins_key,
  input  logic [DATA_W-1:0] ins_data,
  // in-place rewrite of one slot during a swap
  input  logic              swp_en,
  input  logic [SLOT_W-1:0] swp_slot,
  input  logic              swp_valid,
  input  logic [ADDR_W-1:0] swp_key,
  input  logic [DATA_W-1:0] swp_data
);

  logic [DEPTH-1:0]             valid_q;
  logic [DEPTH-1:0]             valid_d;
  logic [DEPTH-1:0][ADDR_W-1:0] key_q;
  logic [DEPTH-1:0][DATA_W-1:0] data_q;
  logic [SLOT_W-1:0]            ptr_q;
  logic [SLOT_W-1:0]            ptr_d;
  logic [DEPTH-1:0]             match_vec;

  // One comparator per slot. All slots are searched at once.
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign match_vec[g] = valid_q[g] && (key_q[g] == lk_key);
  end

  // Slot encoder. Exclusivity keeps match_vec at most one-hot.
  always_comb begin
    lk_slot = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (match_vec[i]) begin
        lk_slot = SLOT_W'(i);
      end
    end
  end

  assign lk_hit  = |match_vec;
  assign lk_data = data_q[lk_slot];

  // Next state for the valid bits and the round-robin fill pointer.
  always_comb begin
    valid_d = valid_q;
    ptr_d   = ptr_q;
    if (ins_en) begin
      valid_d[ptr_q] = 1'b1;
      ptr_d = (ptr_q == SLOT_W'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
    end
    if (swp_en) begin
      valid_d[swp_slot] = swp_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      ptr_q   <= '0;
    end else begin
      valid_q <= valid_d;
      ptr_q   <= ptr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (ins_en) begin
      key_q[ptr_q]  <= ins_key;
      data_q[ptr_q] <= ins_data;
    end
    if (swp_en) begin
      key_q[swp_slot]  <= swp_key;
      data_q[swp_slot] <= swp_data;
    end
  end

endmodule

// File: rtl/dmvc_sat_cnt.sv
`timescale 1ns/1ps
module dmvc_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] cnt
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  assign cnt_en = inc && (cnt_q != {W{1'b1}});

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_en) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/dmvc_cache.sv
`timescale 1ns/1ps
module dmvc_cache
  import dmvc_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32,
  parameter int SETS     = 16,
  parameter int VB_DEPTH = 8,
  parameter int CNT_W    = 16,
  localparam int IDX_W   = $clog2(SETS),
  localparam int TAG_W   = ADDR_W - IDX_W,
  localparam int SLOT_W  = $clog2(VB_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic [CNT_W-1:0]  main_hit_cnt,
  output logic [CNT_W-1:0]  victim_hit_cnt,
  output logic [CNT_W-1:0]  miss_cnt
);

  // ---------------------------------------------------------------
  // Control and response registers
  // ---------------------------------------------------------------
  ctl_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              addr_en;
  logic              rsp_valid_q, rsp_valid_d;
  logic              rsp_hit_q, rsp_hit_d;
  logic [DATA_W-1:0] rsp_data_q, rsp_data_d;
  logic              rsp_data_en;
  logic              mem_req_q, mem_req_d;

  // ---------------------------------------------------------------
  // Lookup path
  // ---------------------------------------------------------------
  logic [ADDR_W-1:0] lk_addr;
  logic [IDX_W-1:0]  lk_idx;
  logic [TAG_W-1:0]  lk_tag;
  logic              accept;

  logic              rd_valid;
  logic [TAG_W-1:0]  rd_tag;
  logic [DATA_W-1:0] rd_data;
  logic              main_hit;

  logic              vb_hit;
  logic [SLOT_W-1:0] vb_slot;
  logic [DATA_W-1:0] vb_data;

  logic              m_wr_en;
  logic [DATA_W-1:0] m_wr_data;
  logic              vb_ins_en;
  logic              vb_swp_en;
  logic [ADDR_W-1:0] evict_key;

  logic [CNT_NUM-1:0]            cnt_inc;
  logic [CNT_NUM-1:0][CNT_W-1:0] cnt_val;

  // In IDLE the lookup follows the incoming request. Otherwise it stays on the held address.
  assign lk_addr   = (state_q == ST_IDLE) ? req_addr : addr_q;
  assign lk_idx    = lk_addr[IDX_W-1:0];
  assign lk_tag    = lk_addr[ADDR_W-1:IDX_W];
  assign accept    = req_valid && (state_q == ST_IDLE);
  assign main_hit  = rd_valid && (rd_tag == lk_tag);
  assign evict_key = {rd_tag, lk_idx};

  dmvc_main_array #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .SETS   (SETS)
  ) u_main (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (lk_idx),
    .rd_valid(rd_valid),
    .rd_tag  (rd_tag),
    .rd_data (rd_data),
    .wr_en   (m_wr_en),
    .wr_idx  (lk_idx),
    .wr_tag  (lk_tag),
    .wr_data (m_wr_data)
  );

  dmvc_victim_buf #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .DEPTH  (VB_DEPTH)
  ) u_vb (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_key   (lk_addr),
    .lk_hit   (vb_hit),
    .lk_slot  (vb_slot),
    .lk_data  (vb_data),
    .ins_en   (vb_ins_en),
    .ins_key  (evict_key),
    .ins_data (rd_data),
    .swp_en   (vb_swp_en),
    .swp_slot (vb_slot),
    .swp_valid(rd_valid),
    .swp_key  (evict_key),
    .swp_data (rd_data)
  );

  // ---------------------------------------------------------------
  // Next-state logic
  // ---------------------------------------------------------------
  always_comb begin
    state_d     = state_q;
    addr_d      = addr_q;
    addr_en     = 1'b0;
    rsp_valid_d = 1'b0;
    rsp_hit_d   = rsp_hit_q;
    rsp_data_d  = rsp_data_q;
    rsp_data_en = 1'b0;
    mem_req_d   = 1'b0;
    m_wr_en     = 1'b0;
    m_wr_data   = vb_data;
    vb_ins_en   = 1'b0;
    vb_swp_en   = 1'b0;
    cnt_inc     = '0;

    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          addr_d  = req_addr;
          addr_en = 1'b1;
          if (main_hit) begin
            rsp_valid_d = 1'b1;
            rsp_hit_d   = 1'b1;
            rsp_data_d  = rd_data;
            rsp_data_en = 1'b1;
            cnt_inc[CNT_MAIN] = 1'b1;
          end else if (vb_hit) begin
            state_d = ST_SWAP;
          end else begin
            state_d   = ST_WAIT;
            mem_req_d = 1'b1;
          end
        end
      end

      ST_SWAP: begin
        // The buffered line enters the main array. The displaced main line,
        // if valid, takes over the same buffer slot.
        m_wr_en     = 1'b1;
        m_wr_data   = vb_data;
        vb_swp_en   = 1'b1;
        rsp_valid_d = 1'b1;
        rsp_hit_d   = 1'b1;
        rsp_data_d  = vb_data;
        rsp_data_en = 1'b1;
        cnt_inc[CNT_VICTIM] = 1'b1;
        state_d     = ST_IDLE;
      end

      ST_WAIT: begin
        if (mem_rsp_valid) begin
          m_wr_en     = 1'b1;
          m_wr_data   = mem_rsp_data;
          vb_ins_en   = rd_valid;
          rsp_valid_d = 1'b1;
          rsp_hit_d   = 1'b0;
          rsp_data_d  = mem_rsp_data;
          rsp_data_en = 1'b1;
          cnt_inc[CNT_MISS] = 1'b1;
          state_d     = ST_IDLE;
        end
      end

      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  // ---------------------------------------------------------------
  // Registers
  // ---------------------------------------------------------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      mem_req_q   <= 1'b0;
    end else begin
      state_q     <= state_d;
      rsp_valid_q <= rsp_valid_d;
      rsp_hit_q   <= rsp_hit_d;
      mem_req_q   <= mem_req_d;
    end
  end

  always_ff @(posedge clk) begin
    if (addr_en) begin
      addr_q <= addr_d;
    end
    if (rsp_data_en) begin
      rsp_data_q <= rsp_data_d;
    end
  end

  // ---------------------------------------------------------------
  // Saturating event counters
  // ---------------------------------------------------------------
  for (genvar g = 0; g < CNT_NUM; g++) begin : g_cnt
    dmvc_sat_cnt #(
      .W (CNT_W)
    ) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .inc  (cnt_inc[g]),
      .cnt  (cnt_val[g])
    );
  end

  assign req_ready      = (state_q == ST_IDLE);
  assign rsp_valid      = rsp_valid_q;
  assign rsp_hit        = rsp_hit_q;
  assign rsp_data       = rsp_data_q;
  assign mem_req_valid  = mem_req_q;
  assign mem_req_addr   = addr_q;
  assign main_hit_cnt   = cnt_val[CNT_MAIN];
  assign victim_hit_cnt = cnt_val[CNT_VICTIM];
  assign miss_cnt       = cnt_val[CNT_MISS];

endmodule

// File: rtl/dmvc_cache_chk.sv
`timescale 1ns/1ps
module dmvc_cache_chk #(
  parameter int ADDR_W   = 16,
  parameter int SETS     = 16,
  parameter int VB_DEPTH = 8,
  parameter int CNT_W    = 16,
  localparam int IDX_W   = $clog2(SETS),
  localparam int TAG_W   = ADDR_W - IDX_W
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           req_valid,
  input  logic                           req_ready,
  input  logic [ADDR_W-1:0]              req_addr,
  input  logic                           rsp_valid,
  input  logic                           rsp_hit,
  input  logic                           mem_req_valid,
  input  logic [ADDR_W-1:0]              mem_req_addr,
  input  logic                           mem_rsp_valid,
  input  logic                           main_hit,
  input  logic                           vb_hit,
  input  logic [SETS-1:0]                main_valid,
  input  logic [SETS-1:0][TAG_W-1:0]     main_tag,
  input  logic [VB_DEPTH-1:0]            vb_valid,
  input  logic [VB_DEPTH-1:0][ADDR_W-1:0] vb_key,
  input  logic [VB_DEPTH-1:0]            vb_match,
  input  logic [CNT_W-1:0]               c_main,
  input  logic [CNT_W-1:0]               c_vic,
  input  logic [CNT_W-1:0]               c_miss
);

  logic acc;
  logic dup;

  assign acc = req_valid && req_ready;

  // Some buffered line is also valid in the main array under the same tag.
  always_comb begin
    dup = 1'b0;
    for (int i = 0; i < VB_DEPTH; i++) begin
      if (vb_valid[i] && main_valid[vb_key[i][IDX_W-1:0]] &&
          (main_tag[vb_key[i][IDX_W-1:0]] == vb_key[i][ADDR_W-1:IDX_W])) begin
        dup = 1'b1;
      end
    end
  end

  p_miss_request_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !main_hit && !vb_hit) |=> (mem_req_valid && mem_req_addr == $past(req_addr)));

  p_request_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid);

  p_miss_response_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rsp_valid && !req_ready) |=> (rsp_valid && !rsp_hit && req_ready));

  p_main_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && main_hit) |=> (rsp_valid && rsp_hit && !mem_req_valid));

  p_victim_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !main_hit && vb_hit) |=> (!rsp_valid && !mem_req_valid) ##1 (rsp_valid && rsp_hit));

  p_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !dup);

  p_single_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(vb_match));

  p_cnt_saturate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (c_main >= $past(c_main)) && (c_vic >= $past(c_vic)) && (c_miss >= $past(c_miss)));

  p_miss_count_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit && $past(c_miss) != {CNT_W{1'b1}}) |->
      (c_miss == $past(c_miss) + 1'b1));

endmodule

bind dmvc_cache dmvc_cache_chk #(
  .ADDR_W  (ADDR_W),
  .SETS    (SETS),
  .VB_DEPTH(VB_DEPTH),
  .CNT_W   (CNT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_addr     (req_addr),
  .rsp_valid    (rsp_valid),
  .rsp_hit      (rsp_hit),
  .mem_req_valid(mem_req_valid),
  .mem_req_addr (mem_req_addr),
  .mem_rsp_valid(mem_rsp_valid),
  .main_hit     (main_hit),
  .vb_hit       (vb_hit),
  .main_valid   (u_main.valid_q),
  .main_tag     (u_main.tag_q),
  .vb_valid     (u_vb.valid_q),
  .vb_key       (u_vb.key_q),
  .vb_match     (u_vb.match_vec),
  .c_main       (main_hit_cnt),
  .c_vic        (victim_hit_cnt),
  .c_miss       (miss_cnt)
);

// File: tb/dmvc_cache_bench.sv
`timescale 1ns/1ps
module dmvc_cache_bench;

  localparam int AW  = 16;
  localparam int DW  = 32;
  localparam int NS  = 4;
  localparam int VD  = 4;
  localparam int CW  = 4;
  localparam int LAT = 3;
  localparam int K_HIT = 0;
  localparam int K_VIC = 1;
  localparam int K_MISS = 2;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic [AW-1:0] req_addr;
  logic          req_ready;
  logic          rsp_valid;
  logic          rsp_hit;
  logic [DW-1:0] rsp_data;
  logic          mem_req_valid;
  logic [AW-1:0] mem_req_addr;
  logic          mem_rsp_valid;
  logic [DW-1:0] mem_rsp_data;
  logic [CW-1:0] main_hit_cnt;
  logic [CW-1:0] victim_hit_cnt;
  logic [CW-1:0] miss_cnt;

  int n_chk;
  int n_bad;
  int e_main;
  int e_vic;
  int e_miss;

  dmvc_cache #(
    .ADDR_W  (AW),
    .DATA_W  (DW),
    .SETS    (NS),
    .VB_DEPTH(VD),
    .CNT_W   (CW)
  ) u_dmvc_cache (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_addr      (req_addr),
    .req_ready     (req_ready),
    .rsp_valid     (rsp_valid),
    .rsp_hit       (rsp_hit),
    .rsp_data      (rsp_data),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .main_hit_cnt  (main_hit_cnt),
    .victim_hit_cnt(victim_hit_cnt),
    .miss_cnt      (miss_cnt)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
    return {~a, a};
  endfunction

  // Line address from tag and index (index = low bits, R2).
  function automatic logic [AW-1:0] la(input int tag, input int idx);
    return AW'(tag * NS + idx);
  endfunction

  function automatic int sat(input int v);
    return (v < CMAX) ? v + 1 : v;
  endfunction

  task automatic chk(input string rq, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic chk_counts(input string rq);
    chk(rq, "main_hit_cnt", DW'(main_hit_cnt), DW'(e_main));
    chk(rq, "victim_hit_cnt", DW'(victim_hit_cnt), DW'(e_vic));
    chk(rq, "miss_cnt", DW'(miss_cnt), DW'(e_miss));
  endtask

  task automatic do_reset();
    rst_n         = 1'b0;
    req_valid     = 1'b0;
    req_addr      = '0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    e_main = 0;
    e_vic  = 0;
    e_miss = 0;
  endtask

  // Starts and ends on a falling edge. kind selects the expected path.
  task automatic access(input logic [AW-1:0] a, input int kind, input string rq);
    chk(rq, "req_ready before request", DW'(req_ready), DW'(1));
    req_valid = 1'b1;
    req_addr  = a;
    @(negedge clk);
    req_valid = 1'b0;
    if (kind == K_HIT) begin
      chk(rq, "hit rsp_valid", DW'(rsp_valid), DW'(1));
      chk(rq, "hit rsp_hit", DW'(rsp_hit), DW'(1));
      chk(rq, "hit rsp_data", rsp_data, mem_word(a));
      chk(rq, "hit no mem_req", DW'(mem_req_valid), DW'(0));
      e_main = sat(e_main);
    end else if (kind == K_VIC) begin
      chk(rq, "victim early rsp_valid", DW'(rsp_valid), DW'(0));
      chk(rq, "victim no mem_req", DW'(mem_req_valid), DW'(0));
      @(negedge clk);
      chk(rq, "victim rsp_valid", DW'(rsp_valid), DW'(1));
      chk(rq, "victim rsp_hit", DW'(rsp_hit), DW'(1));
      chk(rq, "victim rsp_data", rsp_data, mem_word(a));
      chk(rq, "victim no mem_req late", DW'(mem_req_valid), DW'(0));
      e_vic = sat(e_vic);
    end else begin
      chk(rq, "miss mem_req_valid", DW'(mem_req_valid), DW'(1));
      chk(rq, "miss mem_req_addr", DW'(mem_req_addr), DW'(a));
      chk(rq, "miss early rsp_valid", DW'(rsp_valid), DW'(0));
      for (int i = 0; i < LAT; i++) begin
        @(negedge clk);
        chk(rq, "miss req_ready low", DW'(req_ready), DW'(0));
        chk(rq, "miss single pulse", DW'(mem_req_valid), DW'(0));
      end
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = mem_word(a);
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      mem_rsp_data  = '0;
      chk(rq, "miss rsp_valid", DW'(rsp_valid), DW'(1));
      chk(rq, "miss rsp_hit", DW'(rsp_hit), DW'(0));
      chk(rq, "miss rsp_data", rsp_data, mem_word(a));
      e_miss = sat(e_miss);
    end
  endtask

  task automatic t_reset_state();
    chk("R1", "req_ready", DW'(req_ready), DW'(1));
    chk("R1", "rsp_valid", DW'(rsp_valid), DW'(0));
    chk("R1", "mem_req_valid", DW'(mem_req_valid), DW'(0));
    chk_counts("R1");
  endtask

  task automatic t_basic();
    access(la(1, 1), K_MISS, "R1");   // cold line is a miss
    access(la(1, 1), K_HIT,  "R4");
    access(la(2, 2), K_MISS, "R3");
    access(la(1, 1), K_HIT,  "R2");   // different index still present
    access(la(2, 2), K_HIT,  "R2");
    chk_counts("R11");
  endtask

  task automatic t_victim_swap();
    access(la(3, 1), K_MISS, "R5");   // evicts la(1,1) into the buffer
    access(la(1, 1), K_VIC,  "R5");
    access(la(1, 1), K_HIT,  "R7");   // swapped back, served from main
    access(la(3, 1), K_VIC,  "R6");   // displaced line sits in the buffer
    access(la(3, 1), K_HIT,  "R6");
    access(la(1, 1), K_VIC,  "R6");
    chk_counts("R11");
  endtask

  task automatic t_fifo_and_invalid();
    do_reset();
    t_reset_state();
    access(la(1, 0), K_MISS, "R8");   // invalid line replaced
    access(la(2, 0), K_MISS, "R9");   // t1 -> slot 0
    access(la(3, 0), K_MISS, "R9");   // t2 -> slot 1
    access(la(4, 0), K_MISS, "R9");   // t3 -> slot 2
    access(la(1, 1), K_MISS, "R8");   // invalid line on index 1
    access(la(5, 0), K_MISS, "R9");   // t4 -> slot 3
    access(la(6, 0), K_MISS, "R9");   // t5 -> slot 0, drops tag 1
    access(la(2, 0), K_VIC,  "R8");   // survives only if no slot was wasted
    access(la(1, 0), K_MISS, "R9");   // oldest victim was discarded
    access(la(3, 0), K_VIC,  "R9");
    chk_counts("R11");
  endtask

  task automatic t_saturation();
    for (int i = 0; i < 20; i++) begin
      access(la(3, 0), K_HIT, "R10");
    end
    chk("R10", "main_hit_cnt saturated", DW'(main_hit_cnt), DW'(CMAX));
    chk_counts("R10");
  endtask

  initial begin
    n_chk  = 0;
    n_bad  = 0;
    do_reset();
    t_reset_state();
    t_basic();
    t_victim_swap();
    t_fifo_and_invalid();
    t_saturation();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule